// File: doc/BRIEF.md
# SAR Converter Sampling Controller

This block runs an external 12-bit successive-approximation converter with a parallel output bus at a fixed sample rate. It drives the converter's chip-select and read/convert control lines, watches the converter's busy line through a synchronizer, and takes each finished result from the bus. Each result leaves the block as a signed word with a one-cycle valid strobe.

The sequencer has four states. `ST_IDLE` waits for the rate timer and `enable`. `ST_SETUP` holds read/convert low while chip-select is still high, so the converter sees chip-select as the initiating edge. `ST_PULSE` holds both lines low for the minimum convert-pulse width. `ST_READ` puts the converter into read mode and waits for busy to rise.

The transitions are these. Start goes from `ST_IDLE` to `ST_SETUP` in dual-line mode, or from `ST_IDLE` to `ST_PULSE` in single-line mode. Setup done goes from `ST_SETUP` to `ST_PULSE`. Pulse done goes from `ST_PULSE` to `ST_READ`. Capture goes from `ST_READ` to `ST_IDLE` on a synchronized busy rise. Timeout goes from `ST_READ` to `ST_IDLE` when busy does not rise in time.

In single-line mode chip-select is held low, and read/convert alone selects converting or reading. The bus is only ever an input here, so the controller never contends with the converter while the converter drives it.

Top module: `adc_sample_ctl`

## Requirements
- R1: While `rst_n` is low, `adc_cs_n` and `adc_rc` are high, `smp_valid` is low and `err_timeout` is low.
- R2: In dual-line mode, `adc_rc` goes low 2 clock cycles (10 ns at 200 MHz) before `adc_cs_n` falls. `adc_cs_n` is high whenever the sequencer is idle.
- R3: The convert pulse keeps both lines low for 8 cycles (40 ns). After it, `adc_rc` returns high while `adc_cs_n` stays low until the sample is taken.
- R4: A rise of `adc_busy` is passed through a two-flop synchronizer. `smp_valid` pulses for exactly one cycle, on the third rising clock edge after `adc_busy` rises.
- R5: `smp_data` equals the bus word present at capture, unchanged, read as two's complement (0x7FF is the largest positive value, 0x800 the most negative).
- R6: Successive conversion starts (falls of `adc_rc`) are spaced max(`period_cfg`, 332) cycles apart, where 332 cycles is 1.66 us. A setting below 332, including 0, is clamped to 332.
- R7: In single-line mode (`single_line` = 1), `adc_cs_n` stays low at all times and only `adc_rc` toggles.
- R8: If busy does not rise within 520 cycles of entering the read state (twice the 1.3 us conversion time), `err_timeout` sets and stays set until reset. The sequencer then returns to idle and later samples still complete.
- R9: While `enable` is low, no new conversion is started. A conversion already in flight still completes and delivers its sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new conversions to start |
| single_line | input | 1 | 1: chip-select held low, read/convert alone controls the converter |
| period_cfg | input | 16 | Sample period in clock cycles (clamped to 332 minimum) |
| adc_busy | input | 1 | Converter busy line, asynchronous, low while converting |
| adc_bus | input | 12 | Converter parallel data bus |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Converter read/convert line (low = convert, high = read) |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |
| smp_data | output | 12 | Signed sample word |
| err_timeout | output | 1 | Sticky flag: busy never returned high |

## Verification
A sequencer stuck in the wrong state shows up within one cycle on `adc_cs_n` or `adc_rc`, because both lines are decoded straight from the state. A miscounted step counter moves the edges of the setup window or the convert pulse by whole cycles, which an every-cycle compare catches at the first wrong edge. A fault in the rate timer appears as a wrong spacing between `adc_rc` falls, which is visible by the second conversion. A fault in the synchronizer or edge detector moves `smp_valid` off the third edge after busy rises, or drops the sample, so the returned data queue diverges at once.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_READ
    } ctl_state_t;

    // cycles needed to cover a time given in picoseconds, rounded up
    function automatic int ps_to_cycles(input int span_ps, input int clk_ps);
        return (span_ps + clk_ps - 1) / clk_ps;
    endfunction
endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_async,
    output logic busy_rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= busy_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[STAGES-1];
    end

    assign busy_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
    parameter int PW      = 16,
    parameter int MIN_PER = 332
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_cfg,
    input  logic          restart,
    output logic          ready
);
    localparam logic [PW-1:0] MIN_V = PW'(MIN_PER);

    logic [PW-1:0] since_q;
    logic [PW-1:0] eff_per;

    assign eff_per = (period_cfg < MIN_V) ? MIN_V : period_cfg;
    assign ready   = since_q >= (eff_per - PW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)              since_q <= '1;
        else if (restart)        since_q <= '0;
        else if (since_q != '1)  since_q <= since_q + PW'(1);
    end
endmodule

// File: rtl/adc_ctl_fsm.sv
module adc_ctl_fsm
    import adc_ctl_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 8,
    parameter int TIMEOUT_CYC = 520
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       single_line,
    input  logic       ready,
    input  logic       busy_rise,
    output logic       start,
    output logic       capture,
    output logic       timeout,
    output ctl_state_t state_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    ctl_state_t    state_q, state_d;
    logic [CW-1:0] step_q, step_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    always_comb begin
        state_d = state_q;
        step_d  = step_q + CW'(1);
        start   = 1'b0;
        capture = 1'b0;
        timeout = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                step_d = '0;
                if (enable && ready) begin
                    start   = 1'b1;
                    state_d = single_line ? ST_PULSE : ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (step_q == CW'(SETUP_CYC - 1)) begin
                    state_d = ST_PULSE;
                    step_d  = '0;
                end
            end
            ST_PULSE: begin
                if (step_q == CW'(PULSE_CYC - 1)) begin
                    state_d = ST_READ;
                    step_d  = '0;
                end
            end
            ST_READ: begin
                if (busy_rise) begin
                    capture = 1'b1;
                    state_d = ST_IDLE;
                    step_d  = '0;
                end else if (step_q == CW'(TIMEOUT_CYC - 1)) begin
                    timeout = 1'b1;
                    state_d = ST_IDLE;
                    step_d  = '0;
                end
            end
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/adc_sample_ctl.sv
module adc_sample_ctl
    import adc_ctl_pkg::*;
#(
    parameter int CLK_PS      = 5000,
    parameter int DW          = 12,
    parameter int PW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_PS    = 40000,
    parameter int SETUP_PS    = 10000,
    parameter int CYCLE_PS    = 1660000,
    parameter int CONV_PS     = 1300000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 single_line,
    input  logic [PW-1:0]        period_cfg,
    input  logic                 adc_busy,
    input  logic [DW-1:0]        adc_bus,
    output logic                 adc_cs_n,
    output logic                 adc_rc,
    output logic                 smp_valid,
    output logic signed [DW-1:0] smp_data,
    output logic                 err_timeout
);
    localparam int PULSE_CYC   = ps_to_cycles(PULSE_PS, CLK_PS);
    localparam int SETUP_CYC   = ps_to_cycles(SETUP_PS, CLK_PS);
    localparam int MIN_PER_CYC = ps_to_cycles(CYCLE_PS, CLK_PS);
    localparam int CONV_CYC    = ps_to_cycles(CONV_PS, CLK_PS);
    localparam int TIMEOUT_CYC = 2 * CONV_CYC;

    logic       busy_rise, ready, start, capture, timeout;
    ctl_state_t state;

    adc_busy_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .busy_async(adc_busy), .busy_rise(busy_rise)
    );

    adc_rate_timer #(.PW(PW), .MIN_PER(MIN_PER_CYC)) rate_i (
        .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg),
        .restart(start), .ready(ready)
    );

    adc_ctl_fsm #(
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .single_line(single_line),
        .ready(ready), .busy_rise(busy_rise), .start(start),
        .capture(capture), .timeout(timeout), .state_o(state)
    );

    // control pins decoded from the sequencer state
    always_comb begin
        unique case (state)
            ST_IDLE:  begin adc_cs_n = ~single_line; adc_rc = 1'b1; end
            ST_SETUP: begin adc_cs_n = 1'b1;         adc_rc = 1'b0; end
            ST_PULSE: begin adc_cs_n = 1'b0;         adc_rc = 1'b0; end
            ST_READ:  begin adc_cs_n = 1'b0;         adc_rc = 1'b1; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid   <= 1'b0;
            smp_data    <= '0;
            err_timeout <= 1'b0;
        end else begin
            smp_valid <= capture;
            if (capture) smp_data <= adc_bus;
            if (timeout) err_timeout <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_sample_ctl_chk.sv
module adc_sample_ctl_chk #(
    parameter int MIN_PER   = 332,
    parameter int PULSE_CYC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic single_line,
    input logic adc_cs_n,
    input logic adc_rc,
    input logic smp_valid,
    input logic err_timeout
);
    logic [15:0] low_cnt, gap_cnt;
    logic        rc_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            gap_cnt <= '1;
            rc_last <= 1'b1;
        end else begin
            rc_last <= adc_rc;
            if (!adc_rc) low_cnt <= (low_cnt == '1) ? low_cnt : low_cnt + 16'd1;
            else         low_cnt <= '0;
            if (rc_last && !adc_rc)  gap_cnt <= 16'd1;
            else if (gap_cnt != '1)  gap_cnt <= gap_cnt + 16'd1;
        end
    end

    AST_RC_BEFORE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_line && $fell(adc_cs_n)) |-> !adc_rc); // R2
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rc) |-> (low_cnt >= 16'(PULSE_CYC))); // R3
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid); // R4
    AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_rc) |-> (gap_cnt >= 16'(MIN_PER))); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout); // R8
endmodule

bind adc_sample_ctl adc_sample_ctl_chk #(
    .MIN_PER(MIN_PER_CYC), .PULSE_CYC(PULSE_CYC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .single_line(single_line), .adc_cs_n(adc_cs_n),
    .adc_rc(adc_rc), .smp_valid(smp_valid), .err_timeout(err_timeout)
);

// File: tb/adc_sample_ctl_tb_top.sv
module adc_sample_ctl_tb_top;
    localparam int MINP = 332, SETC = 2, PULC = 8, TMOC = 520;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0, enable = 1'b0, single_line = 1'b0;
    logic [15:0] period_cfg = 16'd100;
    logic        adc_busy = 1'b1;
    logic [11:0] adc_bus = 12'h000;
    logic        adc_cs_n, adc_rc, smp_valid, err_timeout;
    logic signed [11:0] smp_data;

    adc_sample_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .single_line(single_line),
        .period_cfg(period_cfg), .adc_busy(adc_busy), .adc_bus(adc_bus),
        .adc_cs_n(adc_cs_n), .adc_rc(adc_rc), .smp_valid(smp_valid),
        .smp_data(smp_data), .err_timeout(err_timeout)
    );

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference of the controller ----------------
    int  m_st = 0, m_step = 0, m_per = 65535, m_eff = MINP;
    bit  m_valid = 0, m_err = 0, s1 = 1, s2 = 1, sp = 1, m_rise = 0, m_go = 0;
    logic [11:0] m_data = 12'h000;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_step = 0; m_per = 65535; m_valid = 0; m_err = 0;
            m_data = 12'h000; s1 = 1; s2 = 1; sp = 1;
        end else begin
            m_rise  = s2 && !sp;
            m_eff   = (int'(period_cfg) < MINP) ? MINP : int'(period_cfg);
            m_go    = 0;
            m_valid = 0;
            case (m_st)
                0: if (enable && m_per >= m_eff - 1) begin
                    m_go = 1; m_step = 0; m_st = single_line ? 2 : 1;
                end
                1: begin m_step++; if (m_step == SETC) begin m_st = 2; m_step = 0; end end
                2: begin m_step++; if (m_step == PULC) begin m_st = 3; m_step = 0; end end
                default: begin
                    if (m_rise) begin
                        m_valid = 1; m_data = adc_bus; m_st = 0; m_step = 0;
                    end else begin
                        m_step++;
                        if (m_step == TMOC) begin m_err = 1; m_st = 0; m_step = 0; end
                    end
                end
            endcase
            m_per = m_go ? 0 : ((m_per < 65535) ? m_per + 1 : m_per);
            sp = s2; s2 = s1; s1 = adc_busy;
        end
    end

    // ---------------- converter model ----------------
    bit adc_dead = 0, prev_cond = 0;
    int conv_len = 260, left = 0, code_i = 0;
    logic [11:0] exp_q[$];

    function automatic logic [11:0] code_of(input int i);
        case (i % 5)
            0: return 12'h7FF;
            1: return 12'h800;
            2: return 12'h000;
            3: return 12'hFFF;
            default: return 12'((i * 37 + 5) & 12'hFFF);
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            adc_busy = 1; prev_cond = 0;
        end else begin
            if (adc_busy && !adc_cs_n && !adc_rc && !prev_cond && !adc_dead) begin
                adc_busy = 0; left = conv_len; adc_bus = 12'hAAA;
            end else if (!adc_busy) begin
                left--;
                if (left == 0) begin
                    adc_bus = code_of(code_i); exp_q.push_back(adc_bus);
                    code_i++; adc_busy = 1;
                end
            end
            prev_cond = !adc_cs_n && !adc_rc;
        end
    end

    // ---------------- per-cycle compare ----------------
    int  cyc = 0, last_fall = -1, exp_gap = 0, falls_off = 0, cs_hi_single = 0;
    int  valids = 0, e_cs = 1, e_rc = 1;
    bit  rc_seen = 1, off_win = 0, single_win = 0;
    logic [11:0] popped;

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            cyc++;
            e_cs = (m_st == 0) ? int'(!single_line) : (m_st == 1) ? 1 : 0;
            e_rc = (m_st == 1 || m_st == 2) ? 0 : 1;
            check(adc_cs_n == e_cs[0], single_line ? "R7 cs_n" : "R2 cs_n", adc_cs_n, e_cs);
            check(adc_rc == e_rc[0], "R3 rc", adc_rc, e_rc);
            check(smp_valid == m_valid, "R4 valid", smp_valid, m_valid);
            check(err_timeout == m_err, "R8 err", err_timeout, m_err);
            if (smp_valid) begin
                valids++;
                check(smp_data == m_data, "R5 data", smp_data, m_data);
                if (exp_q.size() > 0) begin
                    popped = exp_q.pop_front();
                    check(smp_data == popped, "R5 bus word", smp_data, popped);
                end else check(0, "R5 queue empty", smp_data, 0);
            end
            if (rc_seen && !adc_rc) begin
                if (exp_gap > 0 && last_fall >= 0)
                    check(cyc - last_fall == exp_gap, "R6 gap", cyc - last_fall, exp_gap);
                last_fall = cyc;
                if (off_win) falls_off++;
            end
            if (single_win && adc_cs_n) cs_hi_single++;
            rc_seen = adc_rc;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                check(0, "watchdog", 0, 1);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        join_none

        repeat (4) @(negedge clk);
        check(adc_cs_n === 1'b1 && adc_rc === 1'b1, "R1 pins", {adc_cs_n, adc_rc}, 2'b11);
        check(smp_valid === 1'b0 && err_timeout === 1'b0, "R1 flags", {smp_valid, err_timeout}, 0);
        rst_n = 1'b1;

        // dual-line, short period clamped to the minimum
        @(negedge clk); enable = 1; exp_gap = MINP;
        repeat (1200) @(negedge clk);
        // longer period
        period_cfg = 16'd400; last_fall = -1; exp_gap = 400;
        repeat (1300) @(negedge clk);
        // disabled
        enable = 0; exp_gap = 0;
        repeat (2) @(negedge clk);
        off_win = 1;
        repeat (900) @(negedge clk);
        off_win = 0;
        check(falls_off == 0, "R9 starts while disabled", falls_off, 0);
        check(exp_q.size() == 0, "R9 in-flight sample delivered", exp_q.size(), 0);
        // single-line mode with slower conversions
        single_line = 1; period_cfg = 16'd340; conv_len = 300; last_fall = -1; exp_gap = 340;
        single_win = 1; enable = 1;
        repeat (1200) @(negedge clk);
        single_win = 0;
        check(cs_hi_single == 0, "R7 cs held low", cs_hi_single, 0);
        // dead converter: timeout, period 0 clamps
        enable = 0; repeat (400) @(negedge clk);
        single_line = 0; period_cfg = 16'd0; conv_len = 260; adc_dead = 1; exp_gap = 0;
        enable = 1;
        repeat (1200) @(negedge clk);
        check(err_timeout == 1'b1, "R8 timeout flag", err_timeout, 1);
        adc_dead = 0; valids = 0;
        repeat (1500) @(negedge clk);
        check(valids > 0, "R8 recovery samples", valids, 1);
        check(err_timeout == 1'b1, "R8 flag sticky", err_timeout, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule